// File: doc/BRIEF.md
# Biphase Bit-Period Decoder

This block recovers data bits from a demodulated single-wire line that carries biphase code: the line toggles at every bit boundary, and a one bit adds a second toggle half way through the bit. The line is first brought into the clock domain through two flip-flops. A saturating counter then measures the time from each edge to the next, in system clocks. Each interval is sorted by its length into one of three classes. It can match a full bit period, it can be half of one that pairs with its neighbour, or it can be a gap that is too long. The nominal period in clocks is the parameter `BIT_CLKS`, which is the system clock rate divided by 2000 for a 2 kbit/s line.

The decoder holds at most one earlier interval. A full-period interval gives a 0. Two intervals that together make a full period give a 1. When a gap longer than the tolerance is followed by a falling edge half a period later, that edge alone gives a 1, so the first bit after a quiet line is not lost. An over-long interval that decodes as nothing raises a one-cycle idle pulse, which tells downstream framing logic to drop any partial byte. Framing, byte assembly and packet handling sit outside this block.

Top module: `biphase_rx`

## Requirements
- R1: After reset, `bit_valid` and `idle_pulse` are low and stay low while `line_in` holds low.
- R2: With no interval pending, an edge interval L with 0.75·P < L < 1.25·P (P = `BIT_CLKS`) gives one strobe with `bit_value` = 0.
- R3: When a pending interval and the new interval sum to a value strictly inside the window, the decoder gives one strobe with `bit_value` = 1 and then holds no pending interval.
- R4: The window is strict at both ends. An interval of exactly 0.75·P or exactly 1.25·P is not a full period, and it stays pending for pairing.
- R5: An edge interval longer than 1.25·P that gives no bit raises `idle_pulse` for one cycle. It never pairs with a pending half interval, and the next full-period interval still decodes as 0.
- R6: On a falling edge, when the pending interval is longer than 1.25·P and the new interval doubled lies inside the window, the decoder gives a 1 at once.
- R7: On a rising edge, the rule in R6 does not apply. The half interval waits and pairs with the next interval under R3.
- R8: The interval counter saturates at 2·P. However long the line stays still, the next edge is seen as an over-long gap and never as a bit.
- R9: A strobe on `bit_valid` or `idle_pulse` appears 3 clock edges after the edge on `line_in`: two to synchronise and one to register the decision.
- R10: `bit_valid` is never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Demodulated biphase line, asynchronous |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_value | output | 1 | Decoded bit, valid while `bit_valid` is high |
| idle_pulse | output | 1 | One-cycle strobe when an over-long gap ends with no bit decoded |

## Verification
Two functions can meet in one cycle: the counter reaching its saturation value, and an edge arriving that restarts the counter. The bench provokes this by holding the line for exactly 2·P clocks and then for 2·P+1 clocks. Both intervals must come out as gaps that raise `idle_pulse` and give no bit, and a following full-period interval must still decode as 0. A second meeting point is an over-long gap that closes while a half interval is pending. The bench leaves half a period pending, then sends a long gap, and judges that no 1 is produced and that the next full period gives 0.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

  // Interval lies strictly between 3/4 and 5/4 of the nominal period.
  function automatic logic in_window(input logic [31:0] len, input logic [31:0] per);
    return ((len * 32'd4) > (per * 32'd3)) && ((len * 32'd4) < (per * 32'd5));
  endfunction

  // Interval lies strictly above 5/4 of the nominal period.
  function automatic logic is_long(input logic [31:0] len, input logic [31:0] per);
    return (len * 32'd4) > (per * 32'd5);
  endfunction

endpackage

// File: rtl/bpd_edge_sync.sv
module bpd_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic edge_o,
  output logic fall_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= line_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign edge_o = sync_q ^ last_q;
  assign fall_o = last_q & ~sync_q;

  AST_FALL_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> edge_o);  // R6
endmodule

// File: rtl/bpd_interval_ctr.sv
module bpd_interval_ctr #(
  parameter int unsigned CNT_MAX = 200,
  parameter int unsigned CW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_i,
  output logic [CW-1:0] len_o
);
  localparam logic [CW-1:0] MAXV = CW'(CNT_MAX);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  // Counts clocks since the last edge; starts saturated so the first edge is a gap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= MAXV;
    else if (edge_i)         cnt_q <= ONE;
    else if (cnt_q != MAXV)  cnt_q <= cnt_q + ONE;
  end

  assign len_o = cnt_q;

  AST_CNT_STAYS_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    (len_o == MAXV && !edge_i) |=> (len_o == MAXV));  // R8
  AST_CNT_RESTARTS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> (len_o == ONE));  // R9
endmodule

// File: rtl/bpd_pair_decoder.sv
module bpd_pair_decoder
  import bpd_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 100,
  parameter int unsigned CW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_i,
  input  logic          fall_i,
  input  logic [CW-1:0] len_i,
  output logic          bit_valid_o,
  output logic          bit_value_o,
  output logic          abort_o,
  output logic          hist_empty_o
);
  localparam logic [31:0] PER = 32'(BIT_CLKS);

  logic          pend_q;
  logic [CW-1:0] pend_len_q;
  logic [CW:0]   pair_sum;
  logic          pair_one, lead_one, full_zero, gap_long;
  logic          dec_one, dec_zero, dec_abort;

  assign pair_sum  = {1'b0, pend_len_q} + {1'b0, len_i};
  assign pair_one  = pend_q && in_window(32'(pair_sum), PER);
  assign lead_one  = pend_q && fall_i && in_window(32'({len_i, 1'b0}), PER)
                     && is_long(32'(pend_len_q), PER);
  assign full_zero = in_window(32'(len_i), PER);
  assign gap_long  = is_long(32'(len_i), PER);

  assign dec_one   = edge_i && (pair_one || lead_one);
  assign dec_zero  = edge_i && !dec_one && full_zero;
  assign dec_abort = edge_i && !dec_one && !full_zero && gap_long;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_len_q  <= '0;
      bit_valid_o <= 1'b0;
      bit_value_o <= 1'b0;
      abort_o     <= 1'b0;
    end else begin
      bit_valid_o <= dec_one || dec_zero;
      bit_value_o <= dec_one;
      abort_o     <= dec_abort;
      if (edge_i) begin
        pend_q     <= !(dec_one || dec_zero);
        pend_len_q <= len_i;
      end
    end
  end

  assign hist_empty_o = !pend_q;

  AST_HIST_CLEAR_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> hist_empty_o);  // R3
  AST_STROBE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid_o || abort_o) |-> $past(edge_i));  // R9
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |=> !bit_valid_o);  // R10
  AST_ABORT_NOT_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !bit_valid_o);  // R5
endmodule

// File: rtl/biphase_rx.sv
module biphase_rx
  import bpd_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic bit_valid,
  output logic bit_value,
  output logic idle_pulse
);
  localparam int unsigned CNT_MAX = 2 * BIT_CLKS;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  logic          edge_w, fall_w, hist_empty_w;
  logic [CW-1:0] len_w;

  bpd_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .edge_o(edge_w), .fall_o(fall_w)
  );

  bpd_interval_ctr #(.CNT_MAX(CNT_MAX), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .len_o(len_w)
  );

  bpd_pair_decoder #(.BIT_CLKS(BIT_CLKS), .CW(CW)) u_dec (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .fall_i(fall_w), .len_i(len_w),
    .bit_valid_o(bit_valid), .bit_value_o(bit_value), .abort_o(idle_pulse),
    .hist_empty_o(hist_empty_w)
  );

  AST_FULL_PERIOD_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && hist_empty_w && in_window(32'(len_w), 32'(BIT_CLKS)))
      |=> (bit_valid && !bit_value));  // R2
endmodule

// File: tb/sim_biphase_rx.sv
`timescale 1ns/1ps
module sim_biphase_rx;
  localparam int P = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b0;
  logic bit_valid, bit_value, idle_pulse;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int nbits = 0;
  int aborts = 0;
  int doubles = 0;
  int first_cyc = -1;
  int drive_cyc = 0;
  logic got [0:31];
  logic prev_valid = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  biphase_rx #(.BIT_CLKS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .bit_valid(bit_valid), .bit_value(bit_value), .idle_pulse(idle_pulse)
  );

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) begin
        if (nbits == 0) first_cyc = cyc;
        if (nbits < 32) got[nbits] = bit_value;
        nbits++;
      end
      if (bit_valid && prev_valid) doubles++;
      prev_valid = bit_valid;
      if (idle_pulse) aborts++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic toggle_after(input int n);
    repeat (n) @(negedge clk);
    line_in = ~line_in;
    drive_cyc = cyc;
  endtask

  // Bring the line to want_low ? 0 : 1, let it rest, clear tallies, then one edge (a gap).
  task automatic gap(input bit want_low);
    if (line_in == want_low) toggle_after(5);
    repeat (300) @(negedge clk);
    @(posedge clk);
    nbits = 0; aborts = 0; first_cyc = -1;
    toggle_after(2);
  endtask

  task automatic settle;
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_bits(input string req, input int n, input logic [31:0] pat);
    check(req, "bit count", nbits, n);
    for (int i = 0; i < n && i < nbits; i++)
      check(req, $sformatf("bit %0d", i), int'(got[i]), int'(pat[i]));
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "bit_valid after reset", int'(bit_valid), 0);
    check("R1", "idle_pulse after reset", int'(idle_pulse), 0);
    repeat (50) @(negedge clk);
    check("R1", "strobes on quiet line", nbits + aborts, 0);
  endtask

  task automatic t_zeros;
    int lat;
    gap(1'b1);
    toggle_after(P);
    lat = drive_cyc;
    repeat (3) toggle_after(P);
    settle();
    expect_bits("R2", 4, 32'b0000);
    check("R5", "gap pulses", aborts, 1);
    check("R9", "latency edge to strobe", first_cyc - lat, 3);
  endtask

  task automatic t_ones;
    gap(1'b1);
    toggle_after(P);
    toggle_after(P/2); toggle_after(P/2);
    toggle_after(40);  toggle_after(60);
    toggle_after(P);
    toggle_after(30);  toggle_after(60);
    settle();
    expect_bits("R3", 5, 32'b10110);
    check("R3", "gap pulses", aborts, 1);
  endtask

  task automatic t_bounds;
    gap(1'b1);
    toggle_after(P);
    toggle_after(76);
    toggle_after(124);
    toggle_after(75);
    toggle_after(25);
    toggle_after(125);
    toggle_after(300);
    settle();
    expect_bits("R4", 4, 32'b1000);
    check("R4", "gap pulses", aborts, 2);
  endtask

  task automatic t_lead_fall;
    gap(1'b1);
    toggle_after(P/2);
    toggle_after(P/2);
    toggle_after(P/2);
    settle();
    expect_bits("R6", 2, 32'b11);
    check("R6", "gap pulses", aborts, 1);
  endtask

  task automatic t_lead_rise;
    gap(1'b0);
    toggle_after(P/2);
    toggle_after(P/2);
    toggle_after(P/2);
    settle();
    expect_bits("R7", 1, 32'b1);
    check("R7", "gap pulses", aborts, 1);
  endtask

  task automatic t_discard;
    gap(1'b1);
    toggle_after(P);
    toggle_after(P/2);
    toggle_after(300);
    toggle_after(P);
    settle();
    expect_bits("R5", 2, 32'b00);
    check("R5", "gap pulses", aborts, 2);
  endtask

  task automatic t_saturate;
    gap(1'b1);
    toggle_after(2660);
    toggle_after(P);
    settle();
    expect_bits("R8", 1, 32'b0);
    check("R8", "gap pulses", aborts, 2);
  endtask

  task automatic t_meet;
    gap(1'b1);
    toggle_after(2*P);
    toggle_after(2*P + 1);
    toggle_after(P);
    settle();
    expect_bits("R8", 1, 32'b0);
    check("R8", "gap pulses at saturation", aborts, 3);
  endtask

  initial begin
    t_reset();
    t_zeros();
    t_ones();
    t_bounds();
    t_lead_fall();
    t_lead_rise();
    t_discard();
    t_saturate();
    t_meet();
    check("R10", "back-to-back strobes", doubles, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule